// File: doc/BRIEF.md
# Region-Configured External Bus Controller

This block connects a processor core to a 32-bit external bus that carries address and data on separate pins. The core posts byte, halfword or word reads and writes into a short request queue. For each request the controller selects one of sixteen memory regions from the top four address bits. That region's configuration sets the external port width, the internal wait-state count, whether bursting is allowed and the byte order. The controller then runs as many external bus phases as the request needs. It places each byte on the correct lane. For reads it gathers the returned bytes and hands the result back to the core in the core's own (little-endian) value order.

Accesses that are misaligned, or wider than the region's port, are broken into a run of aligned phases at increasing addresses. Wait states are counted inside the controller. An external ready input can stretch any phase further. When a region allows bursting, a split request issues its address strobe only once and streams the remaining phases with no added wait states. Each request ends with a one-clock completion pulse, and completions come back in the order the requests were accepted.

Top module: `xbc_top`

## Requirements
- R1: While reset is high and on the first clock after it, `req_ready` is 1, `bus_cyc` is 0 and `resp_valid` is 0.
- R2: A write with `cfg_we` high loads the 8-bit configuration of region `cfg_sel`. Bits [1:0] set the width (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit), bits [5:2] set the wait count, bit 6 enables bursting and bit 7 selects big-endian. After reset every region is 32-bit, zero waits, no burst, little-endian. The region of a request is `req_addr[31:28]`.
- R3: Up to three accepted requests wait in the queue behind the one on the bus. `req_ready` is low while three are waiting, so with the bus stalled exactly four requests are accepted.
- R4: Every accepted request produces exactly one `resp_valid` pulse one clock wide, in acceptance order. For reads, `resp_rdata` carries the data.
- R5: In a 32-bit region, a phase whose first byte is at address c enables lanes starting at c mod 4. `bus_addr` is the byte address of the first byte moved in that phase. Lane L of the bus holds the byte at address (c with its two low bits cleared) + L.
- R6: In a 16-bit region, bytes use lanes 0–1, with lane = address mod 2. In an 8-bit region every byte uses lane 0. A word request becomes two or four phases at increasing addresses.
- R7: A misaligned request is completed as successive phases. Each phase moves the bytes from the current address up to the end of that port-width-aligned unit, or up to the end of the request if that comes first.
- R8: In a region without bursting, every phase begins with a one-clock `bus_ads` and lasts wait+1 clocks while `bus_rdy` is high.
- R9: In a bursting region, only the first phase of a request asserts `bus_ads` and takes wait states. Each later phase lasts one clock while `bus_rdy` is high.
- R10: In a little-endian region, the byte at request address a+j is value byte j. In a big-endian region, it is value byte n−1−j for an n-byte request. Read data is reassembled by the same rule.
- R11: While `bus_rdy` is low at the end of the wait count, the phase holds its address, enables and direction, and does not complete.
- R12: `bus_last` is high during every clock of the final phase of a request, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_sel | input | 4 | Region being configured |
| cfg_wdata | input | 8 | Region configuration value |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Queue can take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2/3 = word |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write value, low bytes significant |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_rdata | output | 32 | Read value, zero-extended |
| bus_cyc | output | 1 | External phase in progress |
| bus_ads | output | 1 | Address strobe, first clock of an addressed phase |
| bus_wr | output | 1 | Phase direction |
| bus_last | output | 1 | Final phase of the request |
| bus_addr | output | 32 | Byte address of the phase |
| bus_be | output | 4 | Lane enables |
| bus_wdata | output | 32 | Write lanes |
| bus_rdata | input | 32 | Read lanes |
| bus_rdy | input | 1 | External ready, extends a phase when low |

## Verification
The assertions assume three things about the inputs. A region's configuration does not change while a request for that region is queued or running. No request spans the top of its region. The external side eventually raises `bus_rdy`. The bench writes configuration only while the controller is idle. It keeps every address in the low 64 bytes of its region, so the widest misaligned word stays inside the region. It holds `bus_rdy` low only for a bounded stall before releasing it.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    BW8   = 2'd0,
    BW16  = 2'd1,
    BW32  = 2'd2,
    BW32X = 2'd3
  } bw_e;

  // 8-bit region configuration word
  typedef struct packed {
    logic       big_end;
    logic       burst;
    logic [3:0] waits;
    bw_e        width;
  } rcfg_t;

  localparam rcfg_t RCFG_RESET = '{big_end: 1'b0, burst: 1'b0, waits: 4'd0, width: BW32};

  typedef struct packed {
    logic              wr;
    logic [1:0]        size;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } req_t;

  function automatic logic [2:0] size_bytes(logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] port_bytes(bw_e w);
    case (w)
      BW8:     return 3'd1;
      BW16:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // first lane used by a phase that starts at byte offset a
  function automatic logic [1:0] lane_lo(logic [1:0] a, bw_e w);
    case (w)
      BW8:     return 2'd0;
      BW16:    return {1'b0, a[0]};
      default: return a;
    endcase
  endfunction

  // bytes moved by one phase: up to the end of the port-aligned unit
  function automatic logic [2:0] phase_len(logic [1:0] a, logic [2:0] rem, bw_e w);
    logic [2:0] room;
    room = port_bytes(w) - {1'b0, lane_lo(a, w)};
    return (rem < room) ? rem : room;
  endfunction

  function automatic logic [3:0] lane_mask(logic [1:0] lo, logic [2:0] k);
    logic [4:0] m;
    m = (5'd1 << k) - 5'd1;
    return m[3:0] << lo;
  endfunction

endpackage

// File: rtl/xbc_req_q.sv
module xbc_req_q #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = store[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

endmodule

// File: rtl/xbc_region_tab.sv
module xbc_region_tab
  import xbc_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output rcfg_t            rd_cfg
);
  localparam int NREG = 1 << SEL_W;

  rcfg_t tab [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_region
    always_ff @(posedge clk) begin
      if (rst)
        tab[g] <= RCFG_RESET;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        tab[g] <= rcfg_t'(wr_data);
    end
  end

  assign rd_cfg = tab[rd_sel];

endmodule

// File: rtl/xbc_seq.sv
module xbc_seq
  import xbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  req_t              q_head,
  input  rcfg_t             head_cfg,
  output logic              q_pop,
  output logic              bus_cyc,
  output logic              bus_ads,
  output logic              bus_wr,
  output logic              bus_last,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output bw_e               act_width,
  output logic              wait_zero
);
  logic                      busy;
  logic [ADDR_W-1:0]         cur_a;
  logic [2:0]                rem, done_b, tot, cur_k;
  logic [1:0]                cur_lo;
  rcfg_t                     cf;
  logic                      is_wr;
  logic [LANES-1:0][7:0]     mb, rb;
  logic [3:0]                wcnt;

  logic                      start, advance, final_ph;
  logic [2:0]                n_h;
  logic [LANES-1:0][7:0]     mb_h, pmb, rb_n;
  logic [ADDR_W-1:0]         pa;
  logic [2:0]                pr, pj, np_k;
  bw_e                       pw;
  logic [1:0]                np_lo;
  logic [LANES-1:0]          np_be;
  logic [DATA_W-1:0]         np_wd, rd_out;

  assign start    = !busy && !q_empty;
  assign q_pop    = start;
  assign advance  = busy && (wcnt == 4'd0) && bus_rdy;
  assign final_ph = advance && (rem == cur_k);

  // head bytes placed in memory order
  always_comb begin
    n_h = size_bytes(q_head.size);
    for (int j = 0; j < LANES; j++) begin
      int ix;
      ix = head_cfg.big_end ? (int'(n_h) - 1 - j) : j;
      mb_h[j] = 8'h00;
      if (j < int'(n_h) && ix >= 0 && ix < LANES)
        mb_h[j] = q_head.wdata[8*ix +: 8];
    end
  end

  // planning of the next phase (first phase of head, or follow-on phase)
  always_comb begin
    if (start) begin
      pa  = q_head.addr;
      pr  = n_h;
      pj  = 3'd0;
      pw  = head_cfg.width;
      pmb = mb_h;
    end else begin
      pa  = cur_a + ADDR_W'(cur_k);
      pr  = rem - cur_k;
      pj  = done_b + cur_k;
      pw  = cf.width;
      pmb = mb;
    end
    np_lo = lane_lo(pa[1:0], pw);
    np_k  = phase_len(pa[1:0], pr, pw);
    np_be = lane_mask(np_lo, np_k);
    np_wd = '0;
    for (int l = 0; l < LANES; l++) begin
      int ix;
      ix = int'(pj) + l - int'(np_lo);
      if (np_be[l] && ix >= 0 && ix < LANES)
        np_wd[8*l +: 8] = pmb[ix[1:0]];
    end
  end

  // read gathering and reassembly in value order
  always_comb begin
    rb_n = rb;
    for (int l = 0; l < LANES; l++) begin
      int ix;
      ix = int'(done_b) + l - int'(cur_lo);
      if (bus_be[l] && ix >= 0 && ix < LANES)
        rb_n[ix[1:0]] = bus_rdata[8*l +: 8];
    end
    rd_out = '0;
    for (int j = 0; j < LANES; j++) begin
      int ix;
      ix = cf.big_end ? (int'(tot) - 1 - j) : j;
      if (j < int'(tot) && ix >= 0 && ix < LANES)
        rd_out[8*j +: 8] = rb_n[ix[1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cur_a      <= '0;
      rem        <= '0;
      done_b     <= '0;
      tot        <= '0;
      cur_k      <= '0;
      cur_lo     <= '0;
      cf         <= RCFG_RESET;
      is_wr      <= 1'b0;
      mb         <= '0;
      rb         <= '0;
      wcnt       <= '0;
      bus_cyc    <= 1'b0;
      bus_ads    <= 1'b0;
      bus_wr     <= 1'b0;
      bus_last   <= 1'b0;
      bus_addr   <= '0;
      bus_be     <= '0;
      bus_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      bus_ads    <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        cur_a     <= q_head.addr;
        rem       <= n_h;
        done_b    <= 3'd0;
        tot       <= n_h;
        cur_k     <= np_k;
        cur_lo    <= np_lo;
        cf        <= head_cfg;
        is_wr     <= q_head.wr;
        mb        <= mb_h;
        rb        <= '0;
        wcnt      <= head_cfg.waits;
        bus_cyc   <= 1'b1;
        bus_ads   <= 1'b1;
        bus_wr    <= q_head.wr;
        bus_last  <= (np_k == n_h);
        bus_addr  <= q_head.addr;
        bus_be    <= np_be;
        bus_wdata <= np_wd;
      end else if (busy) begin
        if (wcnt != 4'd0) begin
          wcnt <= wcnt - 4'd1;
        end else if (bus_rdy) begin
          rb <= rb_n;
          if (final_ph) begin
            busy       <= 1'b0;
            bus_cyc    <= 1'b0;
            bus_last   <= 1'b0;
            bus_be     <= '0;
            resp_valid <= 1'b1;
            resp_rdata <= is_wr ? '0 : rd_out;
          end else begin
            cur_a     <= pa;
            rem       <= pr;
            done_b    <= pj;
            cur_k     <= np_k;
            cur_lo    <= np_lo;
            wcnt      <= cf.burst ? 4'd0 : cf.waits;
            bus_ads   <= !cf.burst;
            bus_last  <= (np_k == pr);
            bus_addr  <= pa;
            bus_be    <= np_be;
            bus_wdata <= np_wd;
          end
        end
      end
    end
  end

  assign act_width = cf.width;
  assign wait_zero = (wcnt == 4'd0);

endmodule

// File: rtl/xbc_top.sv
module xbc_top
  import xbc_pkg::*;
#(
  parameter int QDEPTH = 3,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              bus_cyc,
  output logic              bus_ads,
  output logic              bus_wr,
  output logic              bus_last,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy
);
  localparam int REQ_W = $bits(req_t);

  logic  q_full, q_empty, q_pop, q_push;
  req_t  q_in, q_head;
  rcfg_t head_cfg;
  bw_e   act_width;
  logic  wait_zero;

  assign q_in      = '{wr: req_wr, size: req_size, addr: req_addr, wdata: req_wdata};
  assign q_push    = req_valid && !q_full;
  assign req_ready = !q_full;

  xbc_req_q #(.DEPTH(QDEPTH), .W(REQ_W)) u_q (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .din   (q_in),
    .pop   (q_pop),
    .dout  (q_head),
    .full  (q_full),
    .empty (q_empty)
  );

  xbc_region_tab #(.SEL_W(SEL_W)) u_tab (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .rd_sel  (q_head.addr[ADDR_W-1 -: SEL_W]),
    .rd_cfg  (head_cfg)
  );

  xbc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .head_cfg   (head_cfg),
    .q_pop      (q_pop),
    .bus_cyc    (bus_cyc),
    .bus_ads    (bus_ads),
    .bus_wr     (bus_wr),
    .bus_last   (bus_last),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rdy    (bus_rdy),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .act_width  (act_width),
    .wait_zero  (wait_zero)
  );

endmodule

// File: rtl/xbc_chk.sv
module xbc_chk
  import xbc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_cyc,
  input logic              bus_ads,
  input logic              bus_wr,
  input logic              bus_last,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]  bus_be,
  input logic              bus_rdy,
  input logic              resp_valid,
  input bw_e               act_width,
  input logic              wait_zero
);
  AST_ADS_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_ads |-> bus_cyc); // R8

  AST_LAST_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_last |-> bus_cyc); // R12

  AST_LANES_PRESENT: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> (bus_be != '0)); // R5

  AST_BYTE_PORT_LANE: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && act_width == BW8) |-> (bus_be == 4'b0001)); // R6

  AST_HALF_PORT_LANES: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && act_width == BW16) |-> (bus_be[3:2] == 2'b00)); // R6

  AST_HOLD_DURING_WAIT: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !wait_zero) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wr))); // R8

  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_rdy) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wr))); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R4

endmodule

bind xbc_top xbc_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_cyc    (bus_cyc),
  .bus_ads    (bus_ads),
  .bus_wr     (bus_wr),
  .bus_last   (bus_last),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_rdy    (bus_rdy),
  .resp_valid (resp_valid),
  .act_width  (act_width),
  .wait_zero  (wait_zero)
);

// File: tb/xbc_top_tb.sv
module xbc_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        req_valid, req_ready, req_wr;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        bus_cyc, bus_ads, bus_wr, bus_last;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic        bus_rdy;

  int checks = 0;
  int errors = 0;
  int n_cyc, n_ads, n_last;

  int rw    [16];
  int rbig  [16];
  int rbst  [16];
  int rwait [16];
  logic [7:0] mem [1024];

  always #5 clk = ~clk;

  xbc_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .bus_cyc(bus_cyc), .bus_ads(bus_ads), .bus_wr(bus_wr), .bus_last(bus_last),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy)
  );

  function automatic int midx(logic [31:0] a);
    return int'({a[31:28], a[5:0]});
  endfunction

  function automatic logic [31:0] lane_addr(logic [31:0] a, int l);
    int wb;
    wb = rw[a[31:28]];
    return (a & ~(32'(wb) - 32'd1)) + 32'(l);
  endfunction

  // external memory model
  always_comb begin
    bus_rdata = '0;
    for (int l = 0; l < 4; l++) bus_rdata[8*l +: 8] = mem[midx(lane_addr(bus_addr, l))];
  end

  always @(posedge clk) begin
    if (bus_cyc) begin
      n_cyc = n_cyc + 1;
      if (bus_ads)  n_ads  = n_ads + 1;
      if (bus_last) n_last = n_last + 1;
      if (bus_wr)
        for (int l = 0; l < 4; l++)
          if (bus_be[l]) mem[midx(lane_addr(bus_addr, l))] <= bus_wdata[8*l +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_region(input int r, input int wb, input int big, input int bst, input int wt);
    logic [1:0] wc;
    wc = (wb == 1) ? 2'd0 : (wb == 2) ? 2'd1 : 2'd2;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(r);
    cfg_wdata = {1'(big), 1'(bst), 4'(wt), wc};
    @(negedge clk);
    cfg_we = 1'b0;
    rw[r] = wb; rbig[r] = big; rbst[r] = bst; rwait[r] = wt;
  endtask

  task automatic xfer(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_size = sz; req_addr = a; req_wdata = wd;
    n_cyc = 0; n_ads = 0; n_last = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata;
  endtask

  function automatic int nphase(int a, int n, int w);
    int c, r, cnt;
    c = a; r = n; cnt = 0;
    while (r > 0) begin
      int k;
      k = w - (c % w);
      if (k > r) k = r;
      c += k; r -= k; cnt++;
    end
    return cnt;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, v, vm, exp_mem, act_mem, a;
    int n, np, wt, ecyc, eads, elast, k, got;
    logic [31:0] pre [5];
    bit saw;

    for (int i = 0; i < 16; i++) begin rw[i] = 4; rbig[i] = 0; rbst[i] = 0; rwait[i] = 0; end
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
    rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_wr = 0; req_size = 0; req_addr = 0; req_wdata = 0; bus_rdy = 1'b1;
    n_cyc = 0; n_ads = 0; n_last = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 32'd1);
    chk("R1 cyc in reset", 32'(bus_cyc), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 cyc after reset", 32'(bus_cyc), 32'd0);
    chk("R1 resp after reset", 32'(resp_valid), 32'd0);

    // R2: unconfigured region 7 defaults to a 32-bit single phase
    xfer(1'b1, 2'd2, 32'h7000_0004, 32'h1122_3344, rd);
    chk("R2 default region cycles", 32'(n_cyc), 32'd1);
    chk("R2 default region ads", 32'(n_ads), 32'd1);

    set_region(0, 4, 0, 0, 0);
    set_region(1, 2, 1, 1, 2);
    set_region(2, 1, 0, 1, 1);
    set_region(3, 1, 1, 0, 3);
    set_region(4, 4, 1, 1, 1);
    set_region(5, 2, 0, 0, 0);

    for (int rg = 0; rg < 6; rg++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int off = 0; off < 4; off++) begin
          string tg;
          n  = 1 << sz;
          a  = (32'(rg) << 28) | 32'(16 * sz + off + 4);
          v  = 32'hC3A5_5A3C + 32'(rg) * 32'h0101_0101 + 32'(sz * 16 + off);
          vm = (n == 4) ? v : (v & ((32'd1 << (8 * n)) - 32'd1));
          np = nphase(16 * sz + off + 4, n, rw[rg]);
          wt = rwait[rg];
          if (rbst[rg] != 0) begin
            ecyc = wt + 1 + (np - 1); eads = 1; elast = (np > 1) ? 1 : wt + 1;
          end else begin
            ecyc = np * (wt + 1); eads = np; elast = wt + 1;
          end
          if (rbig[rg] != 0)            tg = "R10";
          else if ((off % n) != 0)      tg = "R7";
          else if (rw[rg] < 4)          tg = "R6";
          else                          tg = "R5";

          xfer(1'b1, 2'(sz), a, v, rd);
          chk((rbst[rg] != 0) ? "R9 write cycles" : "R8 write cycles", 32'(n_cyc), 32'(ecyc));
          chk((rbst[rg] != 0) ? "R9 write strobes" : "R8 write strobes", 32'(n_ads), 32'(eads));
          chk("R12 final phase clocks", 32'(n_last), 32'(elast));
          exp_mem = '0; act_mem = '0;
          for (int j = 0; j < n; j++) begin
            int bi;
            bi = (rbig[rg] != 0) ? (n - 1 - j) : j;
            exp_mem[8*j +: 8] = vm[8*bi +: 8];
            act_mem[8*j +: 8] = mem[midx(a + 32'(j))];
          end
          chk({tg, " memory bytes"}, act_mem, exp_mem);

          xfer(1'b0, 2'(sz), a, 32'hDEAD_BEEF, rd);
          chk({tg, " read back"}, rd, vm);
          chk((rbst[rg] != 0) ? "R9 read cycles" : "R8 read cycles", 32'(n_cyc), 32'(ecyc));
        end
      end
    end

    // R3/R4/R11: queue depth and ordering with a stalled bus
    for (int i = 0; i < 5; i++) begin
      pre[i] = 32'h5000_0000 + 32'(i) * 32'h0011_2233;
      xfer(1'b1, 2'd2, 32'h0000_0020 + 32'(4 * i), pre[i], rd);
    end
    @(negedge clk);
    bus_rdy = 1'b0;
    k = 0; saw = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (resp_valid) saw = 1;
      if (req_ready && k < 5) begin
        req_valid = 1'b1; req_wr = 1'b0; req_size = 2'd2;
        req_addr = 32'h0000_0020 + 32'(4 * k); k++;
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 accepted while stalled", 32'(k), 32'd4);
    chk("R3 ready low when full", 32'(req_ready), 32'd0);
    chk("R11 phase held while not ready", 32'(bus_cyc), 32'd1);
    chk("R11 no completion while not ready", 32'(saw), 32'd0);
    bus_rdy = 1'b1;
    got = 0;
    for (int c = 0; c < 60 && got < 4; c++) begin
      @(negedge clk);
      if (resp_valid) begin
        chk("R4 in-order read data", resp_rdata, pre[got]);
        got++;
      end
    end
    chk("R4 response count", 32'(got), 32'd4);
    chk("R3 ready after drain", 32'(req_ready), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule